// File: doc/BRIEF.md
# Weighted Scan-Enable Generator

This block drives one scan-enable line per scan segment of a self-test engine that runs in two phases. During the pseudo-random phase each segment receives its own random enable stream. The probability that the stream is 1 is set per segment from four weights, all of them at least one half. Each stream is built by combining three pseudo-random bits with gates. A segment that is switched to the conventional schedule instead shifts for a number of cycles equal to its length and then captures for one cycle. During the deterministic phase every segment follows one shared schedule: it shifts for as many cycles as the scan tree is deep, then captures for one cycle.

A 1 on an enable line means the segment shifts. A 0 means it captures. The test-mode pin overrides everything: while it is low, every enable is held at 0 and both schedule counters stay cleared. The weight choice for each segment comes in as static configuration from outside. The shared schedule also produces a one-cycle capture strobe.

Top module: `wse_gen`

## Requirements
- R1: While `test_mode_i` is 0, every bit of `scan_en_o` is 0 and `det_capture_o` is 0, whatever the other inputs are.
- R2: With `test_mode_i`=1, `phase_i`=0 and bit 2 of a segment's configuration at 0, the segment's enable depends only on that segment's random bits. Segment k takes r0, r1 and r2 from `rnd_i[3k]`, `rnd_i[3k+1]` and `rnd_i[3k+2]`. The weight code in configuration bits [1:0] selects the function: 00 gives r0 (p=0.5), 01 gives r0 OR (r1 AND r2) (p=0.625), 10 gives r0 OR r1 (p=0.75), 11 gives r0 OR r1 OR r2 (p=0.875).
- R3: No weight falls below one half: in the weighted mode of R2, a segment's enable is 1 in every cycle in which its r0 is 1.
- R4: With `test_mode_i`=1 and `phase_i`=1, all segments carry the same enable value, and neither `rnd_i` nor `cfg_i` affects it.
- R5: In the deterministic phase the shared enable repeats this pattern: 1 for `depth_i` cycles, then 0 for one cycle.
- R6: `det_capture_o` is 1 exactly in the capture cycles of R5, and never outside the deterministic phase. For a depth of at least 1 it never stays high for two consecutive cycles.
- R7: When the deterministic phase is left, either by `phase_i` falling or by `test_mode_i` falling, its schedule restarts. The first cycle of the next deterministic phase begins a full run of `depth_i` shift cycles.
- R8: With bit 2 of a segment's configuration at 1 and the block in the pseudo-random phase, that segment's enable is 1 for `seg_len_i[k]` cycles and then 0 for one cycle, repeating. The pattern restarts from the first shift cycle each time this mode is entered.
- R9: After reset, both schedules start at their first shift cycle.
- R10: A deterministic depth of 0 gives a capture, with enable 0 and strobe 1, in every cycle of the deterministic phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | 1 = self-test active, 0 = functional mode (all enables 0) |
| phase_i | input | 1 | 0 = pseudo-random phase, 1 = deterministic phase |
| rnd_i | input | 3*NSEG | Three pseudo-random bits per segment |
| cfg_i | input | 3*NSEG | Per segment: [1:0] weight code, [2] conventional schedule |
| depth_i | input | DW | Scan-tree depth, in shift cycles per deterministic pattern |
| seg_len_i | input | LW*NSEG | Length of each segment, for the conventional schedule |
| scan_en_o | output | NSEG | Per-segment scan enable, 1 = shift, 0 = capture |
| det_capture_o | output | 1 | One-cycle strobe marking each deterministic capture cycle |

## Verification
The checker examines, on every cycle, the functional-mode override, the one-half floor for each weighted segment, the agreement of all segments during the deterministic phase, the rule that no segment shifts while the capture strobe is high, the strobe's single-cycle width and the fact that a freshly entered deterministic phase starts by shifting. The exact weight functions for every code and random pattern, the length of each shift run, the conventional per-segment schedules and the restart after leaving a mode can only be confirmed by the bench. Its cycle model follows the whole sequence under directed and randomized mode changes.

// File: rtl/wse_pkg.sv
package wse_pkg;
  localparam int RBITS = 3;
  localparam int CFGW  = 3;
  localparam int CONV_BIT = 2;

  typedef enum logic [1:0] {
    W_HALF  = 2'b00,
    W_5_8   = 2'b01,
    W_3_4   = 2'b10,
    W_7_8   = 2'b11
  } weight_e;

  // Weighted bit from three unbiased random bits; r[0] always forces 1.
  function automatic logic weighted_bit(weight_e w, logic [RBITS-1:0] r);
    logic b;
    case (w)
      W_HALF:  b = r[0];
      W_5_8:   b = r[0] | (r[1] & r[2]);
      W_3_4:   b = r[0] | r[1];
      default: b = r[0] | r[1] | r[2];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/wse_sched_cnt.sv
module wse_sched_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         shift_o,
  output logic         capture_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  function automatic logic [W-1:0] next_count(logic run, logic last, logic [W-1:0] c);
    if (!run || last) return '0;
    return c + 1'b1;
  endfunction

  assign at_end    = (cnt_q >= limit_i);
  assign shift_o   = run_i & ~at_end;
  assign capture_o = run_i & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(run_i, at_end, cnt_q);
  end
endmodule

// File: rtl/wse_weight_sel.sv
module wse_weight_sel
  import wse_pkg::*;
(
  input  logic [CFGW-1:0]  cfg_i,
  input  logic [RBITS-1:0] rnd_i,
  input  logic             conv_shift_i,
  output logic             en_o
);
  always_comb begin
    if (cfg_i[CONV_BIT]) en_o = conv_shift_i;
    else                 en_o = weighted_bit(weight_e'(cfg_i[1:0]), rnd_i);
  end
endmodule

// File: rtl/wse_gen.sv
module wse_gen
  import wse_pkg::*;
#(
  parameter int NSEG = 4,
  parameter int DW   = 6,
  parameter int LW   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_mode_i,
  input  logic                  phase_i,
  input  logic [NSEG*RBITS-1:0] rnd_i,
  input  logic [NSEG*CFGW-1:0]  cfg_i,
  input  logic [DW-1:0]         depth_i,
  input  logic [NSEG*LW-1:0]    seg_len_i,
  output logic [NSEG-1:0]       scan_en_o,
  output logic                  det_capture_o
);
  logic            det_run;
  logic            det_shift;
  logic            det_cap;
  logic [NSEG-1:0] rnd_en;

  assign det_run = test_mode_i & phase_i;

  wse_sched_cnt #(.W(DW)) u_det_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(det_run), .limit_i(depth_i),
    .shift_o(det_shift), .capture_o(det_cap)
  );

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic conv_run;
    logic conv_shift;
    logic conv_cap;
    assign conv_run = test_mode_i & ~phase_i & cfg_i[k*CFGW+CONV_BIT];

    wse_sched_cnt #(.W(LW)) u_conv_cnt (
      .clk(clk), .rst_n(rst_n), .run_i(conv_run),
      .limit_i(seg_len_i[k*LW +: LW]),
      .shift_o(conv_shift), .capture_o(conv_cap)
    );

    wse_weight_sel u_sel (
      .cfg_i(cfg_i[k*CFGW +: CFGW]), .rnd_i(rnd_i[k*RBITS +: RBITS]),
      .conv_shift_i(conv_shift & ~conv_cap), .en_o(rnd_en[k])
    );

    always_comb begin
      if (!test_mode_i) scan_en_o[k] = 1'b0;
      else if (phase_i) scan_en_o[k] = det_shift;
      else              scan_en_o[k] = rnd_en[k];
    end
  end

  assign det_capture_o = det_cap;
endmodule

// File: rtl/wse_gen_chk.sv
module wse_gen_chk
  import wse_pkg::*;
#(
  parameter int NSEG = 4,
  parameter int DW   = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  test_mode_i,
  input logic                  phase_i,
  input logic [NSEG*RBITS-1:0] rnd_i,
  input logic [NSEG*CFGW-1:0]  cfg_i,
  input logic [DW-1:0]         depth_i,
  input logic [NSEG-1:0]       scan_en_o,
  input logic                  det_capture_o
);
  logic [NSEG-1:0] floor_mask;
  logic            enter_det;

  always_comb begin
    for (int k = 0; k < NSEG; k++)
      floor_mask[k] = test_mode_i & ~phase_i & ~cfg_i[k*CFGW+CONV_BIT] & rnd_i[k*RBITS];
  end

  assign enter_det = test_mode_i & phase_i & (depth_i != '0);

  p_func_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode_i |-> (scan_en_o == '0 && !det_capture_o));

  p_half_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o & floor_mask) == floor_mask);

  p_common_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && phase_i) |-> (scan_en_o == '0 || scan_en_o == '1));

  p_cap_no_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det_capture_o |-> scan_en_o == '0);

  p_strobe_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_capture_o |-> (test_mode_i && phase_i));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_capture_o && depth_i != '0) |=> (!det_capture_o || depth_i != $past(depth_i)));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase_i) && enter_det && $past(test_mode_i)) |-> scan_en_o == '1);
endmodule

bind wse_gen wse_gen_chk #(.NSEG(NSEG), .DW(DW)) u_wse_gen_chk (
  .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i), .phase_i(phase_i),
  .rnd_i(rnd_i), .cfg_i(cfg_i), .depth_i(depth_i),
  .scan_en_o(scan_en_o), .det_capture_o(det_capture_o)
);

// File: tb/test_wse_gen.sv
module test_wse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 4;
  localparam int DW = 6;
  localparam int LW = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic test_mode_i = 0;
  logic phase_i = 0;
  logic [NSEG*3-1:0]  rnd_i = '0;
  logic [NSEG*3-1:0]  cfg_i = '0;
  logic [DW-1:0]      depth_i = '0;
  logic [NSEG*LW-1:0] seg_len_i = '0;
  logic [NSEG-1:0]    scan_en_o;
  logic               det_capture_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int det_pos = 0;
  int conv_pos [NSEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  wse_gen #(.NSEG(NSEG), .DW(DW), .LW(LW)) i_wse_gen (
    .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i), .phase_i(phase_i),
    .rnd_i(rnd_i), .cfg_i(cfg_i), .depth_i(depth_i), .seg_len_i(seg_len_i),
    .scan_en_o(scan_en_o), .det_capture_o(det_capture_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected weighted value, written as the probability ladder.
  function automatic bit exp_weight(bit [1:0] code, bit [2:0] r);
    if (r[0]) return 1'b1;
    case (code)
      2'd3: return r[1] | r[2];
      2'd2: return r[1];
      2'd1: return r[1] & r[2];
      default: return 1'b0;
    endcase
  endfunction

  // Compare the outputs with the model, then step the model over one edge.
  task automatic cycle();
    bit [NSEG-1:0] exp_en;
    bit exp_cap;
    string tag;
    #1;
    exp_cap = 0;
    for (int k = 0; k < NSEG; k++) begin
      bit conv = cfg_i[3*k+2];
      if (!test_mode_i) exp_en[k] = 0;
      else if (phase_i) exp_en[k] = (det_pos < int'(depth_i));
      else if (conv) exp_en[k] = (conv_pos[k] < int'(seg_len_i[k*LW +: LW]));
      else exp_en[k] = exp_weight(cfg_i[3*k +: 2], rnd_i[3*k +: 3]);
    end
    if (test_mode_i && phase_i) exp_cap = (det_pos >= int'(depth_i));
    if (!test_mode_i) tag = "R1";
    else if (phase_i) tag = (depth_i == 0) ? "R10" : "R4/R5";
    else tag = (cfg_i[2] | cfg_i[5] | cfg_i[8] | cfg_i[11]) ? "R8" : "R2";
    chk({tag, " scan_en"}, int'(scan_en_o), int'(exp_en));
    chk(test_mode_i && phase_i ? "R6 strobe" : "R1/R6 strobe idle",
        int'(det_capture_o), int'(exp_cap));
    @(posedge clk);
    if (!(test_mode_i && phase_i) || det_pos >= int'(depth_i)) det_pos = 0;
    else det_pos++;
    for (int k = 0; k < NSEG; k++) begin
      bit run = test_mode_i && !phase_i && cfg_i[3*k+2];
      if (!run || conv_pos[k] >= int'(seg_len_i[k*LW +: LW])) conv_pos[k] = 0;
      else conv_pos[k]++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NSEG; k++) conv_pos[k] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset en", int'(scan_en_o), 0);
    chk("R9 reset strobe", int'(det_capture_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: functional mode ignores everything else
    for (int i = 0; i < 20; i++) begin
      rnd_i = NSEG*3'($urandom); cfg_i = NSEG*3'($urandom);
      phase_i = 1'($urandom); depth_i = DW'($urandom);
      cycle();
    end

    // R9: first deterministic cycle after reset is a shift
    test_mode_i = 1; phase_i = 1; depth_i = 4; cfg_i = '0;
    chk_first_shift("R9");

    // R2 / R3: every weight code against all eight random patterns
    phase_i = 0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++) begin
        for (int k = 0; k < NSEG; k++) begin
          cfg_i[3*k +: 3] = 3'(c);
          rnd_i[3*k +: 3] = 3'((r + k) % 8);
        end
        cycle();
      end

    // R4 / R5 / R6: deterministic run with churning random inputs
    phase_i = 1; depth_i = 3;
    for (int i = 0; i < 25; i++) begin
      rnd_i = NSEG*3'($urandom); cfg_i = NSEG*3'($urandom);
      cycle();
    end

    // R7: leave mid-run via phase, re-enter; then via test mode
    phase_i = 0; cfg_i = '0; cycle();
    phase_i = 1; chk_first_shift("R7 phase");
    cycle();
    test_mode_i = 0; cycle();
    test_mode_i = 1; chk_first_shift("R7 test_mode");
    repeat (6) cycle();

    // R10: depth zero
    depth_i = 0;
    repeat (5) cycle();

    // R8: conventional schedule on two segments, lengths 2 and 5
    phase_i = 0;
    seg_len_i = '0;
    seg_len_i[0 +: LW] = 2; seg_len_i[LW +: LW] = 5;
    seg_len_i[2*LW +: LW] = 1; seg_len_i[3*LW +: LW] = 7;
    cfg_i = 12'b000_000_100_100;
    for (int i = 0; i < 20; i++) begin
      rnd_i = NSEG*3'($urandom);
      cycle();
    end
    cfg_i[2] = 0; cycle();
    cfg_i[2] = 1; chk_conv_first("R8 reentry");
    repeat (4) cycle();

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      rnd_i = NSEG*3'($urandom);
      if ($urandom % 16 == 0) cfg_i = NSEG*3'($urandom);
      if ($urandom % 20 == 0) phase_i = ~phase_i;
      if ($urandom % 50 == 0) test_mode_i = ~test_mode_i;
      if ($urandom % 40 == 0) depth_i = DW'($urandom % 9);
      if ($urandom % 40 == 0) seg_len_i = NSEG*LW'($urandom);
      for (int k = 0; k < NSEG; k++)
        seg_len_i[k*LW +: LW] = LW'(seg_len_i[k*LW +: LW] % 10);
      cycle();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk_first_shift(string req);
    #1;
    chk({req, " first shift"}, int'(scan_en_o), (1 << NSEG) - 1);
    cycle();
  endtask

  task automatic chk_conv_first(string req);
    #1;
    chk({req, " seg0 shift"}, int'(scan_en_o[0]), 1);
    cycle();
  endtask
endmodule